// File: doc/BRIEF.md
# Thermistor Temperature Zone Selector

This block sorts the battery temperature into one of six zones. It works from a digitised thermistor divider reading, so no analog logic is in scope. The reading is an 8-bit code that gives the thermistor voltage as a fraction of the divider reference, in steps of 0.5 %. The code falls as the battery warms. A select input tells the block which thermistor is fitted, a 10 kΩ part or a 100 kΩ part. Each part has its own table of crossing points.

Each zone boundary has two thresholds, one for each direction of crossing. The gap between them is wide at the two charge-inhibit limits and narrow at the three boundaries between charging zones.

There are four charging zones. In each one the block drives out that zone's termination-voltage code and maximum-current code, taken from four per-zone configuration fields. In the cold and hot zones charging is blocked and a fault is raised. A termination code of all ones in the active zone also blocks charging and raises a configuration error.

Top module: `tzone_select`

## Requirements
- R1: While reset is asserted, `zone_vld_o`, `cold_flt_o`, `hot_flt_o`, `chg_ok_o` and `cfg_err_o` are 0, and `vterm_o` and `icurr_o` are 0.
- R2: The first rising clock edge after reset places every boundary from the input alone, with no hysteresis. A boundary counts as crossed toward warm when the code is below its cold-going threshold. `zone_vld_o` goes to 1 after that edge and stays 1.
- R3: Zone encoding on `zone_o`:
  - 0 = below 0 °C (cold)
  - 1 = 0–10 °C
  - 2 = 10–45 °C
  - 3 = 45–50 °C
  - 4 = 50–60 °C
  - 5 = above 60 °C (hot)

  `zone_o` equals the number of boundaries currently crossed toward warm. It updates one clock edge after the input is sampled.
- R4: 10 kΩ table (`ntc_sel_i`=0), warm-going codes. The zone moves warmer across a boundary when the code is strictly below its threshold:
  - 0 °C: 133
  - 10 °C: 131
  - 45 °C: 69
  - 50 °C: 62
  - 60 °C: 50
- R5: 10 kΩ table, cold-going codes. The zone moves colder across a boundary when the code is at or above its threshold:
  - 0 °C: 151
  - 10 °C: 132
  - 45 °C: 71
  - 50 °C: 63
  - 60 °C: 62
- R6: 100 kΩ table (`ntc_sel_i`=1), as warm/cold pairs:
  - 0 °C: 140/161
  - 10 °C: 137/140
  - 45 °C: 63/65
  - 50 °C: 54/56
  - 60 °C: 39/54
- R7: A code between a boundary's two thresholds leaves that boundary unchanged. A steady input keeps the zone steady. A change of `ntc_sel_i` applies the new table from the present state.
- R8: After the first evaluation, `cold_flt_o` is 1 exactly in zone 0 and `hot_flt_o` is 1 exactly in zone 5. Neither is ever 1 together with `chg_ok_o`.
- R9: In a charging zone z (1..4), `vterm_o` = `vterm_cfg_i[3*(z-1)+:3]` and `icurr_o` = `icurr_cfg_i[4*(z-1)+:4]`. Termination codes 0..6 mean 3.94, 4.00, 4.05, 4.10, 4.12, 4.15 and 4.18 V. Current code n means 50 mA for n=0 and 100·n mA otherwise.
- R10: Termination code 7 in the active charging zone sets `cfg_err_o`=1 and `chg_ok_o`=0. Whenever `chg_ok_o` is 0, `vterm_o` and `icurr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio_i | input | 8 | Thermistor ratio code, 0.5 % per step |
| ntc_sel_i | input | 1 | 0 = 10 kΩ table, 1 = 100 kΩ table |
| vterm_cfg_i | input | 12 | Four 3-bit termination codes, zone 1 in the low bits |
| icurr_cfg_i | input | 16 | Four 4-bit current codes, zone 1 in the low bits |
| zone_o | output | 3 | Current zone, 0..5 |
| zone_vld_o | output | 1 | Zone has been evaluated since reset |
| cold_flt_o | output | 1 | Cold charge-inhibit fault |
| hot_flt_o | output | 1 | Hot charge-inhibit fault |
| chg_ok_o | output | 1 | Charging allowed with the outputs below |
| cfg_err_o | output | 1 | Invalid termination code in the active zone |
| vterm_o | output | 3 | Selected termination-voltage code |
| icurr_o | output | 4 | Selected maximum-current code |

## Verification
The bench steps the code up and down through each threshold of both tables. It walks one code below, on and above each crossing point, in both directions.

These sweeps catch specific faults:
- A comparator with the wrong polarity or a value off by one moves the zone one cycle of input too early or too late.
- A missing hold band makes the zone chatter at codes between the two thresholds.

A reset into a code of 140 on the 10 kΩ table must give zone 1. A design that applied hysteresis from a cleared state would report cold instead.

Further tests cover the configuration side:
- Invalid termination codes are placed in single zones. A design that checked the wrong field would then allow charging, or block it in the wrong zone.
- Changes of thermistor type made mid-zone show whether the new table takes over from the present state.

// File: rtl/tzone_pkg.sv
package tzone_pkg;

   // Zone numbering: count of boundaries crossed toward warm.
   typedef enum logic [2:0] {
      ZN_COLD = 3'd0,
      ZN_C0   = 3'd1,
      ZN_C1   = 3'd2,
      ZN_C2   = 3'd3,
      ZN_C3   = 3'd4,
      ZN_HOT  = 3'd5
   } zone_e;

   localparam int NUM_BND = 5;
   localparam int NUM_CHG = NUM_BND - 1;

   // Warm-going threshold: code strictly below it crosses toward warm.
   function automatic int bnd_warm(input int tbl, input int idx);
      int v;
      case (idx)
         0: v = (tbl == 0) ? 133 : 140;
         1: v = (tbl == 0) ? 131 : 137;
         2: v = (tbl == 0) ?  69 :  63;
         3: v = (tbl == 0) ?  62 :  54;
         default: v = (tbl == 0) ? 50 : 39;
      endcase
      return v;
   endfunction

   // Cold-going threshold: code at or above it crosses back toward cold.
   function automatic int bnd_cold(input int tbl, input int idx);
      int v;
      case (idx)
         0: v = (tbl == 0) ? 151 : 161;
         1: v = (tbl == 0) ? 132 : 140;
         2: v = (tbl == 0) ?  71 :  65;
         3: v = (tbl == 0) ?  63 :  56;
         default: v = (tbl == 0) ? 62 : 54;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/tzone_hyst_bit.sv
module tzone_hyst_bit #(
   parameter int RATIO_W = 8,
   parameter int WARM_A  = 133,
   parameter int COLD_A  = 151,
   parameter int WARM_B  = 140,
   parameter int COLD_B  = 161
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               sel,
   input  logic               first,
   output logic               warm_q
);
   localparam int MAXV = (1 << RATIO_W) - 1;

   if (WARM_A > COLD_A || WARM_B > COLD_B) begin : g_bad_order
      $error("tzone_hyst_bit: warm threshold above cold threshold");
   end
   if (COLD_A > MAXV || COLD_B > MAXV) begin : g_bad_range
      $error("tzone_hyst_bit: threshold does not fit RATIO_W");
   end

   localparam logic [RATIO_W-1:0] WA = RATIO_W'(WARM_A);
   localparam logic [RATIO_W-1:0] CA = RATIO_W'(COLD_A);
   localparam logic [RATIO_W-1:0] WB = RATIO_W'(WARM_B);
   localparam logic [RATIO_W-1:0] CB = RATIO_W'(COLD_B);

   logic [RATIO_W-1:0] thr_w, thr_c;
   logic               below_w, at_c;

   always_comb begin
      thr_w   = sel ? WB : WA;
      thr_c   = sel ? CB : CA;
      below_w = (ratio < thr_w);
      at_c    = (ratio >= thr_c);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       warm_q <= 1'b0;
      else if (first)   warm_q <= !at_c;
      else if (below_w) warm_q <= 1'b1;
      else if (at_c)    warm_q <= 1'b0;
   end
endmodule

// File: rtl/tzone_cfg_mux.sv
module tzone_cfg_mux #(
   parameter int NZ   = 4,
   parameter int VT_W = 3,
   parameter int IC_W = 4,
   parameter int ZW   = 3
) (
   input  logic [ZW-1:0]      zone,
   input  logic               vld,
   input  logic [NZ*VT_W-1:0] vterm_cfg,
   input  logic [NZ*IC_W-1:0] icurr_cfg,
   output logic [VT_W-1:0]    vterm,
   output logic [IC_W-1:0]    icurr,
   output logic               chg_ok,
   output logic               cfg_err
);
   localparam logic [VT_W-1:0] VT_BAD = '1;

   if (NZ + 1 >= (1 << ZW)) begin : g_bad_zw
      $error("tzone_cfg_mux: ZW too narrow for NZ charging zones");
   end

   logic [VT_W-1:0] vt_sel;
   logic [IC_W-1:0] ic_sel;
   logic            in_chg;

   always_comb begin
      vt_sel = '0;
      ic_sel = '0;
      in_chg = 1'b0;
      for (int z = 0; z < NZ; z++) begin
         if (zone == ZW'(z + 1)) begin
            vt_sel = vterm_cfg[z*VT_W +: VT_W];
            ic_sel = icurr_cfg[z*IC_W +: IC_W];
            in_chg = 1'b1;
         end
      end
      cfg_err = vld && in_chg && (vt_sel == VT_BAD);
      chg_ok  = vld && in_chg && !cfg_err;
      vterm   = chg_ok ? vt_sel : '0;
      icurr   = chg_ok ? ic_sel : '0;
   end
endmodule

// File: rtl/tzone_select.sv
module tzone_select #(
   parameter int RATIO_W = 8,
   parameter int VT_W    = 3,
   parameter int IC_W    = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [RATIO_W-1:0]                  ratio_i,
   input  logic                                ntc_sel_i,
   input  logic [tzone_pkg::NUM_CHG*VT_W-1:0]  vterm_cfg_i,
   input  logic [tzone_pkg::NUM_CHG*IC_W-1:0]  icurr_cfg_i,
   output logic [2:0]                          zone_o,
   output logic                                zone_vld_o,
   output logic                                cold_flt_o,
   output logic                                hot_flt_o,
   output logic                                chg_ok_o,
   output logic                                cfg_err_o,
   output logic [VT_W-1:0]                     vterm_o,
   output logic [IC_W-1:0]                     icurr_o
);
   import tzone_pkg::*;

   localparam int NB = NUM_BND;
   localparam int ZW = $clog2(NB + 1);

   if (RATIO_W < 8) begin : g_bad_rw
      $error("tzone_select: RATIO_W must hold the threshold codes");
   end
   if (ZW != 3) begin : g_bad_zone
      $error("tzone_select: zone port is 3 bits wide");
   end

   logic          first_q, vld_q;
   logic [NB-1:0] warm_flags;
   logic [ZW-1:0] zone_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= 1'b1;
         vld_q   <= 1'b0;
      end else begin
         first_q <= 1'b0;
         vld_q   <= 1'b1;
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_bnd
      tzone_hyst_bit #(
         .RATIO_W (RATIO_W),
         .WARM_A  (bnd_warm(0, b)),
         .COLD_A  (bnd_cold(0, b)),
         .WARM_B  (bnd_warm(1, b)),
         .COLD_B  (bnd_cold(1, b))
      ) u_bit (
         .clk    (clk),
         .rst_n  (rst_n),
         .ratio  (ratio_i),
         .sel    (ntc_sel_i),
         .first  (first_q),
         .warm_q (warm_flags[b])
      );
   end

   always_comb begin
      zone_cnt = '0;
      for (int b = 0; b < NB; b++) zone_cnt = zone_cnt + ZW'(warm_flags[b]);
   end

   assign zone_o     = zone_cnt;
   assign zone_vld_o = vld_q;
   assign cold_flt_o = vld_q && (zone_cnt == ZW'(ZN_COLD));
   assign hot_flt_o  = vld_q && (zone_cnt == ZW'(ZN_HOT));

   tzone_cfg_mux #(
      .NZ   (NUM_CHG),
      .VT_W (VT_W),
      .IC_W (IC_W),
      .ZW   (ZW)
   ) u_cfg (
      .zone      (zone_cnt),
      .vld       (vld_q),
      .vterm_cfg (vterm_cfg_i),
      .icurr_cfg (icurr_cfg_i),
      .vterm     (vterm_o),
      .icurr     (icurr_o),
      .chg_ok    (chg_ok_o),
      .cfg_err   (cfg_err_o)
   );
endmodule

// File: rtl/tzone_select_chk.sv
module tzone_select_chk #(
   parameter int RATIO_W = 8,
   parameter int VT_W    = 3,
   parameter int IC_W    = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [RATIO_W-1:0] ratio_i,
   input logic               ntc_sel_i,
   input logic [2:0]         zone_o,
   input logic               zone_vld_o,
   input logic               cold_flt_o,
   input logic               hot_flt_o,
   input logic               chg_ok_o,
   input logic               cfg_err_o,
   input logic [VT_W-1:0]    vterm_o,
   input logic [IC_W-1:0]    icurr_o
);
   AST_VLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(zone_vld_o) |-> zone_vld_o); // R2

   AST_ZONE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      zone_o <= 3'd5); // R3

   AST_STEADY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(zone_vld_o) && $stable(ratio_i) && $stable(ntc_sel_i)) |=> $stable(zone_o)); // R7

   AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(chg_ok_o && (cold_flt_o || hot_flt_o)) && !(cold_flt_o && hot_flt_o)); // R8

   AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |-> !chg_ok_o && vterm_o == '0 && icurr_o == '0); // R10

   AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !chg_ok_o |-> vterm_o == '0 && icurr_o == '0); // R10
endmodule

bind tzone_select tzone_select_chk #(
   .RATIO_W (RATIO_W),
   .VT_W    (VT_W),
   .IC_W    (IC_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ratio_i    (ratio_i),
   .ntc_sel_i  (ntc_sel_i),
   .zone_o     (zone_o),
   .zone_vld_o (zone_vld_o),
   .cold_flt_o (cold_flt_o),
   .hot_flt_o  (hot_flt_o),
   .chg_ok_o   (chg_ok_o),
   .cfg_err_o  (cfg_err_o),
   .vterm_o    (vterm_o),
   .icurr_o    (icurr_o)
);

// File: tb/tb_tzone_select.sv
module tb_tzone_select;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ratio_i = 8'd100;
   logic        ntc_sel_i = 1'b0;
   logic [11:0] vterm_cfg_i = 12'o6543;
   logic [15:0] icurr_cfg_i = 16'h4F91;
   logic [2:0]  zone_o;
   logic        zone_vld_o, cold_flt_o, hot_flt_o, chg_ok_o, cfg_err_o;
   logic [2:0]  vterm_o;
   logic [3:0]  icurr_o;

   int tests = 0;
   int fails = 0;
   bit m_first;
   bit m_flag [5];

   always #(CLK_PERIOD/2) clk = ~clk;

   tzone_select dut (
      .clk(clk), .rst_n(rst_n), .ratio_i(ratio_i), .ntc_sel_i(ntc_sel_i),
      .vterm_cfg_i(vterm_cfg_i), .icurr_cfg_i(icurr_cfg_i),
      .zone_o(zone_o), .zone_vld_o(zone_vld_o), .cold_flt_o(cold_flt_o),
      .hot_flt_o(hot_flt_o), .chg_ok_o(chg_ok_o), .cfg_err_o(cfg_err_o),
      .vterm_o(vterm_o), .icurr_o(icurr_o)
   );

   // Thresholds from the percentages in tenths, rounded to 0.5 % codes.
   function automatic int pct_code(input int pct10);
      return (pct10 * 2 + 5) / 10;
   endfunction

   function automatic int t_warm(input bit sel, input int i);
      int p10k [5] = '{665, 654, 345, 308, 249};
      int p100k[5] = '{698, 686, 313, 270, 194};
      return pct_code(sel ? p100k[i] : p10k[i]);
   endfunction

   function automatic int t_cold(input bit sel, input int i);
      int p10k [5] = '{756, 662, 353, 315, 308};
      int p100k[5] = '{805, 698, 323, 278, 270};
      return pct_code(sel ? p100k[i] : p10k[i]);
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step(input int r, input bit sel);
      for (int i = 0; i < 5; i++) begin
         if (m_first)                m_flag[i] = (r < t_cold(sel, i));
         else if (r < t_warm(sel, i)) m_flag[i] = 1'b1;
         else if (r >= t_cold(sel, i)) m_flag[i] = 1'b0;
      end
      m_first = 1'b0;
   endtask

   task automatic check_all();
      int z = 0;
      int vt, ic;
      bit chg, err, ok;
      for (int i = 0; i < 5; i++) z += m_flag[i];
      chg = (z >= 1 && z <= 4);
      vt  = chg ? int'(vterm_cfg_i[3*(z-1) +: 3]) : 0;
      ic  = chg ? int'(icurr_cfg_i[4*(z-1) +: 4]) : 0;
      err = chg && vt == 7;
      ok  = chg && !err;
      check("R3 zone", zone_o, z);
      check("R2 vld", zone_vld_o, 1);
      check("R8 cold", cold_flt_o, z == 0);
      check("R8 hot", hot_flt_o, z == 5);
      check("R10 err", cfg_err_o, err);
      check("R10 ok", chg_ok_o, ok);
      check("R9 vterm", vterm_o, ok ? vt : 0);
      check("R9 icurr", icurr_o, ok ? ic : 0);
   endtask

   task automatic apply(input int r, input bit sel);
      @(negedge clk);
      ratio_i   = 8'(r);
      ntc_sel_i = sel;
      @(posedge clk);
      model_step(r, sel);
      #1;
      check_all();
   endtask

   task automatic do_reset(input int r, input bit sel);
      @(negedge clk);
      rst_n = 1'b0;
      ratio_i = 8'(r);
      ntc_sel_i = sel;
      #2;
      check("R1 vld", zone_vld_o, 0);
      check("R1 cold", cold_flt_o, 0);
      check("R1 hot", hot_flt_o, 0);
      check("R1 ok", chg_ok_o, 0);
      check("R1 err", cfg_err_o, 0);
      check("R1 out", {vterm_o, icurr_o}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      m_first = 1'b1;
      @(posedge clk);
      model_step(r, sel);
      #1;
      check_all();
   endtask

   // Step across boundary b of table sel, up and down around both thresholds.
   task automatic sweep_bnd(input bit sel, input int b);
      int w = t_warm(sel, b);
      int c = t_cold(sel, b);
      apply(c + 3, sel);
      apply(w, sel);
      apply(w - 1, sel);
      apply(c - 1, sel);
      apply(c, sel);
      apply(w, sel);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : stim
      int r;
      void'($urandom(32'h5EED1234));
      // R2: reset into 140 on the 10k table must give zone 1 directly
      do_reset(140, 1'b0);
      check("R2 first eval", zone_o, 1);
      for (int b = 0; b < 5; b++) sweep_bnd(1'b0, b);   // R4 R5 R7
      do_reset(150, 1'b1);
      for (int b = 0; b < 5; b++) sweep_bnd(1'b1, b);   // R6 R7
      // R10: invalid termination code only in zone 3
      vterm_cfg_i = 12'o6701;
      apply(100, 1'b0);
      apply(66, 1'b0);
      check("R10 err zone3", cfg_err_o, 1);
      apply(100, 1'b0);
      check("R10 ok zone2", chg_ok_o, 1);
      // R7: table switch mid-band keeps state where both tables hold
      apply(64, 1'b0);
      apply(64, 1'b1);
      // random phase
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(0, 49) == 0) begin
            vterm_cfg_i = 12'($urandom);
            icurr_cfg_i = 16'($urandom);
         end
         if ($urandom_range(0, 1) == 0) r = $urandom_range(0, 255);
         else r = int'(ratio_i) + $urandom_range(0, 6) - 3;
         if (r < 0) r = 0;
         if (r > 255) r = 255;
         apply(r, ($urandom_range(0, 99) == 0) ? !ntc_sel_i : ntc_sel_i);
         if (n == 2000) do_reset($urandom_range(0, 255), 1'($urandom));
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule